// File: doc/BRIEF.md
# Compact Fetch Packet Unpacker

The unpacker takes one 256-bit fetch packet at a time and turns it into an ordered stream of instruction slots. A packet is either standard, holding eight 32-bit instructions, or header-based, where the last word is a descriptor. That descriptor marks which of the first seven words carry a pair of 16-bit instructions and which carry a single 32-bit one. It also supplies the parallel bits for the 16-bit instructions and a set of mode bits that apply to the whole packet.

Each emitted slot carries the raw instruction (a 16-bit instruction is zero-extended, not expanded), a size flag, its parallel bit and the packet's mode attributes. Slots leave on a valid/ready handshake. The block holds one packet, and it accepts the next packet only after the last slot of the current one has been taken.

Top module: `fpk_unpacker`

## Requirements
- R1: After reset, `slot_valid_o` is 0 and `pkt_ready_o` is 1.
- R2: A packet is header-based when bits 31..28 of word 7 (packet bits 255..252) equal 4'b1110. Any other value marks a standard packet, whatever the rest of word 7 holds.
- R3: A standard packet emits eight slots, words 0 to 7 in order. Each slot has `slot_half_o`=0, `slot_par_o` equal to bit 0 of its word, and `slot_attr_o`=0.
- R4: In a header packet, header bit 21+k set to 1 makes word k (k=0..6) a pair of 16-bit instructions. The pair emits two slots, bits 15..0 first and then bits 31..16. Each of them has `slot_half_o`=1 and the halfword in `slot_insn_o[15:0]` with the upper bits zero.
- R5: In a header packet, the parallel bit of the lower halfword of pair word k is header bit 2k, and that of the upper halfword is header bit 2k+1. A 32-bit instruction in a header packet takes its parallel bit from its own bit 0.
- R6: Every slot of a header packet carries `slot_attr_o` equal to header bits 20..14: [6] protected loads, [5] register-set select, [4:2] access size, [1] branch/arithmetic form select, [0] saturation.
- R7: A header packet emits slots for words 0..6 only. The header word never appears as a slot.
- R8: While `slot_valid_o` is 1 and `slot_ready_i` is 0, the slot outputs hold their values and the slot is not consumed.
- R9: `pkt_ready_o` is 0 while any slot of the held packet remains. It returns to 1 in the cycle after the last slot is taken, and an accepted packet presents its first slot in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Fetch packet offered |
| pkt_ready_o | output | 1 | Unpacker can take a packet |
| pkt_data_i | input | 256 | Fetch packet, word k in bits 32k+31..32k |
| slot_valid_o | output | 1 | Slot present |
| slot_ready_i | input | 1 | Consumer takes the slot |
| slot_insn_o | output | 32 | 32-bit instruction or zero-extended halfword |
| slot_half_o | output | 1 | 1 for a 16-bit slot |
| slot_par_o | output | 1 | Parallel bit of the slot |
| slot_attr_o | output | 7 | Packet-wide mode attributes |

## Verification
A wrong word index or half selector shows at once as a slot with the wrong instruction or parallel bit. A stuck half selector shows as a missing or repeated halfword. A miscounted end of packet shows as a header word emitted as a slot, or as a packet cut short. The fault then appears as `pkt_ready_o` rising one slot early or late. Each of these is visible on the first slot handshake that follows the corrupted state, and the accept timing is checked in the cycle after each packet's final slot.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  localparam int INSN_W     = 32;
  localparam int HALF_W     = INSN_W / 2;
  localparam int PKT_WORDS  = 8;
  localparam int PKT_W      = INSN_W * PKT_WORDS;
  localparam int WIDX_W     = $clog2(PKT_WORDS);
  localparam int BODY_WORDS = PKT_WORDS - 1;
  localparam int TAG_W      = 4;
  localparam int ATTR_W     = 7;
  localparam int PBIT_LSB   = 0;
  localparam int ATTR_LSB   = 14;
  localparam int LAYOUT_LSB = 21;
  localparam logic [TAG_W-1:0] HDR_TAG = 4'b1110;

  typedef struct packed {
    logic       prot_ld;
    logic       reg_bank;
    logic [2:0] acc_size;
    logic       alt_form;
    logic       sat;
  } pkt_attr_t;
endpackage

// File: rtl/fpk_hdr_decode.sv
module fpk_hdr_decode
  import fpk_pkg::*;
#(
  parameter logic [TAG_W-1:0] TAG = HDR_TAG
) (
  input  logic [INSN_W-1:0]       word_i,
  output logic                    is_hdr_o,
  output logic [BODY_WORDS-1:0]   layout_o,
  output logic [2*BODY_WORDS-1:0] pbit_o,
  output pkt_attr_t               attr_o
);
  assign is_hdr_o = (word_i[INSN_W-1 -: TAG_W] == TAG);
  assign layout_o = is_hdr_o ? word_i[LAYOUT_LSB +: BODY_WORDS] : '0;
  assign pbit_o   = word_i[PBIT_LSB +: 2*BODY_WORDS];
  assign attr_o   = is_hdr_o ? pkt_attr_t'(word_i[ATTR_LSB +: ATTR_W]) : '0;
endmodule

// File: rtl/fpk_slot_sel.sv
module fpk_slot_sel
  import fpk_pkg::*;
(
  input  logic [PKT_W-1:0]        pkt_i,
  input  logic [WIDX_W-1:0]       widx_i,
  input  logic                    hsel_i,
  input  logic [BODY_WORDS-1:0]   layout_i,
  input  logic [2*BODY_WORDS-1:0] pbit_i,
  output logic                    pair_o,
  output logic [INSN_W-1:0]       insn_o,
  output logic                    par_o
);
  logic [INSN_W-1:0]      words [PKT_WORDS];
  logic [PKT_WORDS-1:0]   layout_ext;
  logic [2*PKT_WORDS-1:0] pbit_ext;
  logic [INSN_W-1:0]      cur;
  logic [HALF_W-1:0]      half;

  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_word
    assign words[g] = pkt_i[g*INSN_W +: INSN_W];
  end

  // the tag word has no layout or parallel bits of its own
  assign layout_ext = {{(PKT_WORDS-BODY_WORDS){1'b0}}, layout_i};
  assign pbit_ext   = {{(2*(PKT_WORDS-BODY_WORDS)){1'b0}}, pbit_i};

  assign cur    = words[widx_i];
  assign pair_o = layout_ext[widx_i];
  assign half   = hsel_i ? cur[INSN_W-1:HALF_W] : cur[HALF_W-1:0];
  assign insn_o = pair_o ? {{(INSN_W-HALF_W){1'b0}}, half} : cur;
  assign par_o  = pair_o ? pbit_ext[{widx_i, hsel_i}] : cur[0];
endmodule

// File: rtl/fpk_unpacker.sv
module fpk_unpacker
  import fpk_pkg::*;
#(
  parameter logic [TAG_W-1:0] HDR_TAG_P = HDR_TAG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [PKT_W-1:0]  pkt_data_i,
  output logic              slot_valid_o,
  input  logic              slot_ready_i,
  output logic [INSN_W-1:0] slot_insn_o,
  output logic              slot_half_o,
  output logic              slot_par_o,
  output logic [ATTR_W-1:0] slot_attr_o
);
  logic [PKT_W-1:0]        pkt_q;
  logic                    held_q;
  logic [WIDX_W-1:0]       widx_q;
  logic                    hsel_q;

  logic                    is_hdr;
  logic [BODY_WORDS-1:0]   layout;
  logic [2*BODY_WORDS-1:0] pbit;
  pkt_attr_t               attr;
  logic                    pair;
  logic [WIDX_W-1:0]       last_idx;
  logic                    take, word_done, pkt_done;

  fpk_hdr_decode #(.TAG(HDR_TAG_P)) i_hdr (
    .word_i   (pkt_q[PKT_W-1 -: INSN_W]),
    .is_hdr_o (is_hdr),
    .layout_o (layout),
    .pbit_o   (pbit),
    .attr_o   (attr)
  );

  fpk_slot_sel i_sel (
    .pkt_i    (pkt_q),
    .widx_i   (widx_q),
    .hsel_i   (hsel_q),
    .layout_i (layout),
    .pbit_i   (pbit),
    .pair_o   (pair),
    .insn_o   (slot_insn_o),
    .par_o    (slot_par_o)
  );

  assign last_idx  = is_hdr ? WIDX_W'(BODY_WORDS-1) : WIDX_W'(PKT_WORDS-1);
  assign take      = held_q & slot_ready_i;
  assign word_done = take & (~pair | hsel_q);
  assign pkt_done  = word_done & (widx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= '0;
      held_q <= 1'b0;
      widx_q <= '0;
      hsel_q <= 1'b0;
    end else if (!held_q) begin
      if (pkt_valid_i) begin
        pkt_q  <= pkt_data_i;
        held_q <= 1'b1;
        widx_q <= '0;
        hsel_q <= 1'b0;
      end
    end else if (take) begin
      if (word_done) begin
        hsel_q <= 1'b0;
        widx_q <= widx_q + 1'b1;
        if (pkt_done) held_q <= 1'b0;
      end else begin
        hsel_q <= 1'b1;
      end
    end
  end

  assign pkt_ready_o  = ~held_q;
  assign slot_valid_o = held_q;
  assign slot_half_o  = held_q & pair;
  assign slot_attr_o  = attr;
endmodule

// File: rtl/fpk_unpacker_chk.sv
module fpk_unpacker_chk
  import fpk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pkt_valid_i,
  input logic              pkt_ready_o,
  input logic              slot_valid_o,
  input logic              slot_ready_i,
  input logic [INSN_W-1:0] slot_insn_o,
  input logic              slot_half_o,
  input logic              slot_par_o,
  input logic [ATTR_W-1:0] slot_attr_o
);
  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_o && !slot_ready_i |=> slot_valid_o && $stable(slot_insn_o) &&
      $stable(slot_half_o) && $stable(slot_par_o) && $stable(slot_attr_o));

  a_r9_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_o |-> !pkt_ready_o);

  a_r9_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o |=> slot_valid_o);

  a_r4_half_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_o && slot_half_o |-> slot_insn_o[INSN_W-1:HALF_W] == '0);

  a_r6_attr_per_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_o && slot_ready_i |=> !slot_valid_o || $stable(slot_attr_o));
endmodule

bind fpk_unpacker fpk_unpacker_chk i_chk (.*);

// File: tb/test_fpk_unpacker.sv
`timescale 1ns/1ps
module test_fpk_unpacker;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pkt_valid_i = 1'b0;
  logic         pkt_ready_o;
  logic [255:0] pkt_data_i = '0;
  logic         slot_valid_o;
  logic         slot_ready_i = 1'b0;
  logic [31:0]  slot_insn_o;
  logic         slot_half_o;
  logic         slot_par_o;
  logic [6:0]   slot_attr_o;

  int checks = 0;
  int errors = 0;

  logic [40:0] exp_q [16];
  int          exp_n;

  always #4 clk_i = ~clk_i;

  fpk_unpacker i_fpk_unpacker (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input logic [6:0] lay, input logic [6:0] attr, input logic [13:0] pb);
    return {4'b1110, lay, attr, pb};
  endfunction

  // expected slot list: {insn, half, par, attr}
  task automatic build_exp(input logic [255:0] p);
    logic [31:0] w7, w;
    logic        hdr;
    logic [6:0]  at;
    w7  = p[255:224];
    hdr = (w7[31:28] == 4'b1110);
    at  = hdr ? w7[20:14] : 7'h0;
    exp_n = 0;
    for (int k = 0; k < (hdr ? 7 : 8); k++) begin
      w = p[32*k +: 32];
      if (hdr && w7[21+k]) begin
        exp_q[exp_n] = {16'h0, w[15:0], 1'b1, w7[2*k], at};     exp_n++;
        exp_q[exp_n] = {16'h0, w[31:16], 1'b1, w7[2*k+1], at};  exp_n++;
      end else begin
        exp_q[exp_n] = {w, 1'b0, w[0], at}; exp_n++;
      end
    end
  endtask

  task automatic run_pkt(input logic [255:0] p, input bit stall, input string tag);
    int n = 0;
    int i = 0;
    logic [40:0] act;
    build_exp(p);
    @(negedge clk_i);
    chk(pkt_ready_o, {tag, " R9 ready before accept"}, 64'(pkt_ready_o), 64'd1);
    pkt_data_i  = p;
    pkt_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    pkt_valid_i = 1'b0;
    chk(slot_valid_o && !pkt_ready_o, {tag, " R9 first slot next cycle"},
        64'({slot_valid_o, pkt_ready_o}), 64'b10);
    while (n < exp_n && i < 200) begin
      act = {slot_insn_o, slot_half_o, slot_par_o, slot_attr_o};
      if (slot_valid_o) begin
        chk(act == exp_q[n], stall && slot_ready_i == 1'b0 && i > 0 ? {tag, " R8 held slot"} : tag,
            64'(act), 64'(exp_q[n]));
        slot_ready_i = stall ? (i % 3 == 2) : 1'b1;
        if (slot_ready_i) n++;
      end else begin
        chk(1'b0, {tag, " R9 slot missing"}, 64'd0, 64'd1);
        n = exp_n;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      i++;
    end
    if (i >= 200) chk(1'b0, {tag, " stream timeout"}, 64'(n), 64'(exp_n));
    slot_ready_i = 1'b0;
    chk(!slot_valid_o && pkt_ready_o, {tag, " R7 R9 packet ends, ready returns"},
        64'({slot_valid_o, pkt_ready_o}), 64'b01);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!slot_valid_o && pkt_ready_o, "R1 reset state", 64'({slot_valid_o, pkt_ready_o}), 64'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!slot_valid_o && pkt_ready_o, "R1 idle after reset", 64'({slot_valid_o, pkt_ready_o}), 64'b01);
  endtask

  task automatic t_standard(input logic [3:0] tag7, input string tag);
    logic [255:0] p;
    for (int k = 0; k < 8; k++) p[32*k +: 32] = 32'hA100_0000 + 32'(k * 32'h0101_0103);
    p[255:252] = tag7;
    p[234:221] = 14'h3FFF; // header-like bits must be ignored
    run_pkt(p, 1'b0, tag);
  endtask

  task automatic t_mixed();
    logic [255:0] p;
    for (int k = 0; k < 7; k++) p[32*k +: 32] = 32'h1357_2468 + 32'(k * 32'h0011_2223);
    p[255:224] = mk_hdr(7'b0011010, 7'b1011010, 14'b00_0111_1000_0100);
    run_pkt(p, 1'b0, "R2 R4 R5 R6 mixed header");
  endtask

  task automatic t_all_pairs_stall();
    logic [255:0] p;
    for (int k = 0; k < 7; k++) p[32*k +: 32] = {16'(16'hB000 + k), 16'(16'hC0F0 + k)};
    p[255:224] = mk_hdr(7'h7F, 7'h25, 14'h2A5C);
    run_pkt(p, 1'b1, "R4 R5 R8 all pairs");
  endtask

  task automatic t_hdr_all32();
    logic [255:0] p;
    for (int k = 0; k < 7; k++) p[32*k +: 32] = 32'h8765_4320 + 32'(k * 3);
    p[255:224] = mk_hdr(7'h00, 7'h40, 14'h0000);
    run_pkt(p, 1'b1, "R5 R6 R7 header all 32-bit");
  endtask

  initial begin
    t_reset();
    t_standard(4'b1111, "R2 R3 standard tag F");
    t_standard(4'b0110, "R2 R3 standard tag 6");
    t_mixed();
    t_all_pairs_stall();
    t_hdr_all32();
    t_mixed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule